// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences a 10-bit successive-approximation converter. A 3-bit source field chooses what starts a conversion. The choices are a software write that sets the busy bit, an overflow pulse from one of four timers, or a rising edge on an external convert-start pin. The pin is asynchronous, so it is first passed through a synchroniser. Once a start is accepted, the block drives a trial code towards the analog side one bit at a time, from the most significant bit down to the least. It samples a single comparator bit to decide whether to keep each trial bit.

When the last bit has been decided, the code is written into the result register. At the same edge the busy flag drops, a sticky done flag is raised, and an interrupt request is raised if it is enabled. Software clears done and the interrupt request with a one-cycle clear strobe. A converter enable lets firmware shut the unit down. While the enable is low, no start is taken, and a conversion already under way is dropped without writing a result.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The source field `start_mode` selects the start source: 3'b000 takes `sw_start`, 3'b001 takes `tmr_ovf[0]`, 3'b010 takes `tmr_ovf[2]`, 3'b011 takes `tmr_ovf[1]`, 3'b100 takes the external pin, and 3'b101 takes `tmr_ovf[3]`. A pulse on a source that is not selected starts nothing.
- R2: The codes 3'b110 and 3'b111 never start a conversion, whatever the inputs do.
- R3: `ext_start` passes through two synchroniser flops, and only its rising edge starts a conversion. If the pin goes high before clock edge E1, the start is accepted at E3. Holding the pin high starts no further conversions.
- R4: `busy` rises at the edge that accepts a start and stays high for exactly 10 clock cycles. It falls at the edge that writes the result.
- R5: A start that arrives while `busy` is high is ignored, including one at the completing edge. A start one cycle after `busy` falls is accepted.
- R6: The approximation runs MSB first. The first trial code on `dac_code` is 10'h200. A trial bit is kept when `cmp_in` is 1, meaning the input is at or above the trial level. The final result is therefore the largest code whose level the input reaches.
- R7: `result` changes only at a completing edge, and each new result replaces the previous one.
- R8: `done` is set at completion and stays set until a `done_clr` strobe. If completion and a clear happen in the same cycle, completion wins.
- R9: `irq` is set at completion only when `irq_en` is high, and it is cleared by `done_clr`. `irq` is never high while `done` is low.
- R10: While `conv_en` is low, every start is ignored. Dropping `conv_en` during a conversion clears `busy` at the next edge, and neither `result` nor `done` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_en | input | 1 | Converter enable; low shuts the unit down |
| start_mode | input | 3 | Start-source select |
| sw_start | input | 1 | Software start strobe (write of 1 to busy) |
| tmr_ovf | input | 4 | Overflow pulses of timers 0 to 3 |
| ext_start | input | 1 | Asynchronous external convert-start pin |
| irq_en | input | 1 | Completion interrupt enable |
| done_clr | input | 1 | Software clear strobe for done and irq |
| cmp_in | input | 1 | Comparator: 1 when input is at or above trial level |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt request |
| result | output | 10 | Latched conversion result |
| dac_code | output | 10 | Trial code driven to the analog side |

## Verification
For every source except the pin, a start strobe present at edge E1 shows `busy` and the trial code 10'h200 after E1. `busy` stays high through E10, and `busy` low, `done`, `irq` and the new `result` all appear after E11. The external pin adds two cycles for the synchroniser. The bench drives every input on the falling edge and counts falling edges from the strobe, so each check lands in the one cycle where its value is first due. Triggers during a conversion, at its completing edge and one cycle after it are placed on exact cycles, and the bench checks that `busy` falls neither earlier nor later than it should.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int RES_W   = 10;
    localparam int NUM_TMR = 4;
    localparam int SYNC_N  = 2;

    typedef enum logic [2:0] {
        SRC_SW   = 3'b000,
        SRC_TMR0 = 3'b001,
        SRC_TMR2 = 3'b010,
        SRC_TMR1 = 3'b011,
        SRC_PIN  = 3'b100,
        SRC_TMR3 = 3'b101
    } start_src_e;
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
    parameter int NUM_TMR = 4,
    parameter int SYNC_N  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         mode,
    input  logic               sw_start,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic               ext_pin,
    output logic               start_req
);
    import adc_seq_pkg::*;

    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              prev;
    } trig_st_t;

    trig_st_t st_d, st_q;
    logic     pin_rise;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_N-2:0], ext_pin};
        st_d.prev = st_q.sync[SYNC_N-1];
        pin_rise  = st_q.sync[SYNC_N-1] & ~st_q.prev;
        case (mode)
            SRC_SW:   start_req = sw_start;
            SRC_TMR0: start_req = tmr_ovf[0];
            SRC_TMR1: start_req = tmr_ovf[1];
            SRC_TMR2: start_req = tmr_ovf[2];
            SRC_TMR3: start_req = tmr_ovf[3];
            SRC_PIN:  start_req = pin_rise;
            default:  start_req = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         start,
    input  logic         cmp_in,
    output logic         busy,
    output logic [W-1:0] dac_code,
    output logic         fin,
    output logic [W-1:0] value
);
    localparam int IW = $clog2(W);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] idx;
        logic [W-1:0]  acc;
    } sar_st_t;

    sar_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        fin      = 1'b0;
        dac_code = st_q.busy ? (st_q.acc | (W'(1) << st_q.idx)) : '0;
        if (!enable) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            if (cmp_in) st_d.acc[st_q.idx] = 1'b1;
            if (st_q.idx == '0) begin
                st_d.busy = 1'b0;
                fin       = 1'b1;
            end else begin
                st_d.idx = st_q.idx - 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.idx  = IW'(W - 1);
            st_d.acc  = '0;
        end
        value = st_d.acc;
        busy  = st_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               conv_en,
    input  logic [2:0]         start_mode,
    input  logic               sw_start,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic               ext_start,
    input  logic               irq_en,
    input  logic               done_clr,
    input  logic               cmp_in,
    output logic               busy,
    output logic               done,
    output logic               irq,
    output logic [RES_W-1:0]   result,
    output logic [RES_W-1:0]   dac_code
);
    typedef struct packed {
        logic [RES_W-1:0] result;
        logic             done;
        logic             irq;
    } flag_st_t;

    flag_st_t         st_d, st_q;
    logic             start_req;
    logic             fin;
    logic [RES_W-1:0] value;

    adc_trig_sel #(.NUM_TMR(NUM_TMR), .SYNC_N(SYNC_N)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (start_mode),
        .sw_start  (sw_start),
        .tmr_ovf   (tmr_ovf),
        .ext_pin   (ext_start),
        .start_req (start_req)
    );

    adc_sar_core #(.W(RES_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (conv_en),
        .start    (start_req),
        .cmp_in   (cmp_in),
        .busy     (busy),
        .dac_code (dac_code),
        .fin      (fin),
        .value    (value)
    );

    always_comb begin
        st_d = st_q;
        if (fin) begin
            st_d.result = value;
            st_d.done   = 1'b1;
            st_d.irq    = st_q.irq | irq_en;
        end else if (done_clr) begin
            st_d.done = 1'b0;
            st_d.irq  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done   = st_q.done;
    assign irq    = st_q.irq;
    assign result = st_q.result;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       conv_en,
    input logic [2:0] start_mode,
    input logic       busy,
    input logic       done,
    input logic       irq,
    input logic [9:0] result
);
    // R10
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(conv_en));
    // R10
    shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_en |=> !busy);
    // R2
    reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_mode[2:1] == 2'b11) |=> !busy);
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(result));
    // R8
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));
    // R9
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_en    (conv_en),
    .start_mode (start_mode),
    .busy       (busy),
    .done       (done),
    .irq        (irq),
    .result     (result)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_en = 1'b1;
    logic [2:0] start_mode = 3'b000;
    logic       sw_start = 1'b0;
    logic [3:0] tmr_ovf = 4'b0;
    logic       ext_start = 1'b0;
    logic       irq_en = 1'b0;
    logic       done_clr = 1'b0;
    logic       cmp_in;
    logic       busy, done, irq;
    logic [9:0] result, dac_code;
    logic [9:0] vin = 10'd0;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;

    assign cmp_in = (dac_code <= vin);

    adc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .start_mode(start_mode),
        .sw_start(sw_start), .tmr_ovf(tmr_ovf), .ext_start(ext_start),
        .irq_en(irq_en), .done_clr(done_clr), .cmp_in(cmp_in),
        .busy(busy), .done(done), .irq(irq), .result(result), .dac_code(dac_code)
    );

    // {irq_en, mode, level}
    localparam logic [13:0] VEC [8] = '{
        {1'b1, 3'b000, 10'h3FF}, {1'b0, 3'b001, 10'h000},
        {1'b1, 3'b010, 10'h155}, {1'b0, 3'b011, 10'h2AA},
        {1'b1, 3'b100, 10'h200}, {1'b1, 3'b101, 10'h1FF},
        {1'b0, 3'b000, 10'h001}, {1'b1, 3'b100, 10'h0C3}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R1 encoding: returns after the negedge that follows the accepting edge
    task automatic fire(input logic [2:0] m);
        case (m)
            3'b000: sw_start = 1'b1;
            3'b001: tmr_ovf[0] = 1'b1;
            3'b011: tmr_ovf[1] = 1'b1;
            3'b010: tmr_ovf[2] = 1'b1;
            3'b101: tmr_ovf[3] = 1'b1;
            3'b100: ext_start = 1'b1;
            default: ;
        endcase
        repeat ((m == 3'b100) ? 3 : 1) @(negedge clk);
        sw_start = 1'b0; tmr_ovf = '0; ext_start = 1'b0;
    endtask

    task automatic clear_done();
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !irq && result == 0, "reset", {busy, done, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 R3 R4 R6 R9
        foreach (VEC[i]) begin
            irq_en = VEC[i][13]; start_mode = VEC[i][12:10]; vin = VEC[i][9:0];
            @(negedge clk);
            fire(VEC[i][12:10]);
            chk(busy, "R1 start taken", busy, 1);
            chk(dac_code == 10'h200, "R6 first trial", dac_code, 10'h200);
            repeat (9) @(negedge clk);
            chk(busy, "R4 busy through cycle 10", busy, 1);
            @(negedge clk);
            chk(!busy && done, "R4 busy falls with done", {busy, done}, 2'b01);
            chk(result == vin, "R6 result", result, vin);
            chk(irq == VEC[i][13], "R9 irq follows enable", irq, VEC[i][13]);
            clear_done();
            chk(!done && !irq, "R8 clear", {done, irq}, 0);
        end

        // R2 reserved codes
        for (int m = 6; m < 8; m++) begin
            start_mode = 3'(m);
            sw_start = 1'b1; tmr_ovf = 4'hF; ext_start = 1'b1;
            repeat (4) @(negedge clk);
            sw_start = 1'b0; tmr_ovf = '0; ext_start = 1'b0;
            chk(!busy, "R2 reserved code", busy, 0);
            repeat (3) @(negedge clk);
        end

        // R1 wrong source: mode selects timer 0, timer 1 pulses
        start_mode = 3'b001; tmr_ovf[1] = 1'b1;
        @(negedge clk); tmr_ovf = '0;
        chk(!busy, "R1 unselected source", busy, 0);

        // R3 pin held high starts only once
        start_mode = 3'b100; vin = 10'h0AA;
        ext_start = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy, "R3 not before third edge", busy, 0);
        @(negedge clk);
        chk(busy, "R3 taken at third edge", busy, 1);
        repeat (10) @(negedge clk);
        chk(!busy && result == 10'h0AA, "R3 result", result, 10'h0AA);
        repeat (4) @(negedge clk);
        chk(!busy, "R3 level does not retrigger", busy, 0);
        ext_start = 1'b0;
        clear_done();

        // R5 R8 R9 R7: trigger mid-run, at completion edge and right after
        start_mode = 3'b000; irq_en = 1'b1; vin = 10'h321;
        fire(3'b000);                       // k=1
        repeat (2) @(negedge clk);          // k=3
        sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;    // k=4
        repeat (6) @(negedge clk);          // k=10
        chk(busy, "R5 mid-run start ignored", busy, 1);
        sw_start = 1'b1; done_clr = 1'b1;
        @(negedge clk);                     // k=11
        done_clr = 1'b0;
        chk(!busy, "R5 completion-edge start ignored", busy, 0);
        chk(done && irq, "R8 completion wins over clear", {done, irq}, 2'b11);
        chk(result == 10'h321, "R7 first result", result, 10'h321);
        vin = 10'h05A;
        @(negedge clk);                     // k=12
        sw_start = 1'b0;
        chk(busy, "R5 start after busy falls", busy, 1);
        chk(result == 10'h321, "R7 held during run", result, 10'h321);
        repeat (9) @(negedge clk);
        chk(done, "R8 sticky", done, 1);
        @(negedge clk);
        chk(!busy && result == 10'h05A, "R7 overwrite", result, 10'h05A);
        clear_done();

        // R9 irq disabled
        irq_en = 1'b0; vin = 10'h111;
        fire(3'b000);
        repeat (10) @(negedge clk);
        chk(done && !irq, "R9 no irq when disabled", {done, irq}, 2'b10);
        clear_done();

        // R10 disabled start and abort
        conv_en = 1'b0;
        fire(3'b000);
        chk(!busy, "R10 start while disabled", busy, 0);
        conv_en = 1'b1; vin = 10'h3C0;
        fire(3'b000);
        repeat (3) @(negedge clk);
        conv_en = 1'b0;
        @(negedge clk);
        chk(!busy, "R10 abort clears busy", busy, 0);
        repeat (12) @(negedge clk);
        chk(!done && result == 10'h111, "R10 abort leaves result", result, 10'h111);
        conv_en = 1'b1;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule